// File: doc/BRIEF.md
# Serial Lane Word Deserializer with Per-Byte Control Flags

This block takes a one-bit serial lane, sampled on every rising edge of the line clock, and rebuilds parallel data words with one control flag per byte. Each byte travels as a ten-bit group made of eight data bits, one control flag and one padding bit. The output pairs a data word with a control vector, the way a wide data/control media interface does, and a strobe marks each new word.

No alignment pattern is searched for. Both ends leave reset together, and the framing counters start from a fixed point. A short lead-in of `LEAD_BITS` sampled bits is skipped, and after that every group boundary follows at a fixed distance. The block is meant for fast link models in which the true port width is carried over a single lane.

Top module: `serial_word_deser`

## Requirements
- R1: A group is 10 consecutive sampled bits sent least significant bit first. Group bits 0..7 are data bits 0..7 of a byte, group bit 8 is that byte's control flag, and group bit 9 is padding.
- R2: The groups of a word arrive lowest byte first. The k-th group after a word boundary fills `data_o[8k+7:8k]` and `ctrl_o[k]`.
- R3: After reset is released, the first `LEAD_BITS` sampled bits (default 1) are discarded whatever their value. The next sampled bit is bit 0 of group 0.
- R4: Words follow one another with no gap. Each word takes exactly `DATA_W/8*10` line-clock cycles (40 for the default 32-bit word).
- R5: `data_o` and `ctrl_o` change together, only on the edge that samples the last bit of a word's last group. They hold their value until the next such edge.
- R6: `word_valid_o` is high for exactly the one cycle that follows the edge completing a word, and low at all other times.
- R7: The padding bit never affects `data_o` or `ctrl_o`. If any padding bit is sampled as 1, `pad_err_o` goes high on that edge and stays high until reset.
- R8: `rst_ni` is asynchronous and active low. It clears `data_o`, `ctrl_o`, `word_valid_o`, `pad_err_o` and the framing counters, and restarts the lead-in skip.
- R9: `DATA_W` is a parameter that must be a multiple of 8 (default 32). `ctrl_o` is `DATA_W/8` bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line clock, one serial bit per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| serial_i | input | 1 | Serial lane bit |
| data_o | output | DATA_W | Rebuilt data word, byte 0 in the low bits |
| ctrl_o | output | DATA_W/8 | Control flag per byte |
| word_valid_o | output | 1 | One-cycle strobe when a word completes |
| pad_err_o | output | 1 | Sticky flag, set when a padding bit was 1 |

## Verification
A bit counter that is off by one shows up in the first word's strobe at the ports. Every byte appears shifted by a bit, and the control and padding positions trade places. The sticky pad flag often rises within the first 40 cycles after the lead-in. A wrong byte counter gives a strobe at the wrong spacing, or bytes landing in the wrong lanes, and this is visible at the next word boundary. A reset that fails to restart the lead-in corrupts the very first word after release.

// File: rtl/deser_pkg.sv
package deser_pkg;
  localparam int BYTE_W     = 8;
  localparam int GROUP_BITS = 10;
  localparam int LAST_BIT   = GROUP_BITS - 1;

  // bit 9 pad, bit 8 control, bits 7..0 data
  typedef struct packed {
    logic             pad;
    logic             ctrl;
    logic [BYTE_W-1:0] data;
  } group_t;
endpackage

// File: rtl/lane_framer.sv
module lane_framer
  import deser_pkg::*;
#(
  parameter int NUM_BYTES = 4,
  parameter int LEAD_BITS = 1,
  localparam int BYTE_IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int LEAD_CNT_W = $clog2(LEAD_BITS + 2)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output logic                  sample_en_o,
  output logic [BYTE_IDX_W-1:0] byte_idx_o,
  output logic                  group_end_o,
  output logic                  word_end_o
);
  localparam logic [LEAD_CNT_W-1:0] LEAD_END  = LEAD_CNT_W'(LEAD_BITS);
  localparam logic [BYTE_IDX_W-1:0] LAST_BYTE = BYTE_IDX_W'(NUM_BYTES - 1);
  localparam logic [3:0]            BIT_END   = 4'(LAST_BIT);

  logic [LEAD_CNT_W-1:0] lead_cnt;
  logic [3:0]            bit_idx;
  logic [BYTE_IDX_W-1:0] byte_idx;
  logic                  in_lead;

  assign in_lead     = (lead_cnt < LEAD_END);
  assign sample_en_o = !in_lead;
  assign group_end_o = sample_en_o && (bit_idx == BIT_END);
  assign word_end_o  = group_end_o && (byte_idx == LAST_BYTE);
  assign byte_idx_o  = byte_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lead_cnt <= '0;
      bit_idx  <= '0;
      byte_idx <= '0;
    end else if (in_lead) begin
      lead_cnt <= lead_cnt + 1'b1;
    end else if (bit_idx == BIT_END) begin
      bit_idx  <= '0;
      byte_idx <= (byte_idx == LAST_BYTE) ? '0 : byte_idx + 1'b1;
    end else begin
      bit_idx <= bit_idx + 1'b1;
    end
  end

  a_r3_lead_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(in_lead) && !in_lead) |-> (bit_idx == 4'd0 && byte_idx == '0));
  a_r4_group_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    group_end_o |=> (bit_idx == 4'd0));
  a_r4_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_en_o && !group_end_o) |=> (bit_idx == $past(bit_idx) + 4'd1));
endmodule

// File: rtl/group_shifter.sv
module group_shifter
  import deser_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sample_en_i,
  input  logic   serial_i,
  output group_t group_o
);
  // the nine most recent bits, oldest at bit 0
  logic [GROUP_BITS-2:0] sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sr <= '0;
    else if (sample_en_i) sr <= {serial_i, sr[GROUP_BITS-2:1]};
  end

  assign group_o = group_t'({serial_i, sr});
endmodule

// File: rtl/word_assembler.sv
module word_assembler
  import deser_pkg::*;
#(
  parameter int NUM_BYTES = 4,
  localparam int BYTE_IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        group_end_i,
  input  logic                        word_end_i,
  input  logic [BYTE_IDX_W-1:0]       byte_idx_i,
  input  logic [BYTE_W-1:0]           byte_i,
  input  logic                        ctrl_bit_i,
  output logic [NUM_BYTES*BYTE_W-1:0] data_o,
  output logic [NUM_BYTES-1:0]        ctrl_o,
  output logic                        word_valid_o
);
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    if (b < NUM_BYTES - 1) begin : g_stage
      logic [BYTE_W-1:0] st_data;
      logic              st_ctrl;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          st_data <= '0;
          st_ctrl <= 1'b0;
        end else if (group_end_i && byte_idx_i == BYTE_IDX_W'(b)) begin
          st_data <= byte_i;
          st_ctrl <= ctrl_bit_i;
        end
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          data_o[b*BYTE_W +: BYTE_W] <= '0;
          ctrl_o[b]                  <= 1'b0;
        end else if (word_end_i) begin
          data_o[b*BYTE_W +: BYTE_W] <= st_data;
          ctrl_o[b]                  <= st_ctrl;
        end
      end
    end else begin : g_last
      // the final byte goes straight from the lane to the output
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          data_o[b*BYTE_W +: BYTE_W] <= '0;
          ctrl_o[b]                  <= 1'b0;
        end else if (word_end_i) begin
          data_o[b*BYTE_W +: BYTE_W] <= byte_i;
          ctrl_o[b]                  <= ctrl_bit_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_valid_o <= 1'b0;
    else         word_valid_o <= word_end_i;
  end

  a_r5_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_end_i |=> ($stable(data_o) && $stable(ctrl_o)));
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);
endmodule

// File: rtl/serial_word_deser.sv
module serial_word_deser
  import deser_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int LEAD_BITS = 1,
  localparam int NUM_BYTES  = DATA_W / BYTE_W,
  localparam int BYTE_IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 serial_i,
  output logic [DATA_W-1:0]    data_o,
  output logic [NUM_BYTES-1:0] ctrl_o,
  output logic                 word_valid_o,
  output logic                 pad_err_o
);
  initial begin
    a_r9_width_multiple: assert (DATA_W % BYTE_W == 0 && DATA_W > 0);
  end

  logic                  sample_en;
  logic [BYTE_IDX_W-1:0] byte_idx;
  logic                  group_end;
  logic                  word_end;
  group_t                grp;

  lane_framer #(.NUM_BYTES(NUM_BYTES), .LEAD_BITS(LEAD_BITS)) u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sample_en_o (sample_en),
    .byte_idx_o  (byte_idx),
    .group_end_o (group_end),
    .word_end_o  (word_end)
  );

  group_shifter u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sample_en_i (sample_en),
    .serial_i    (serial_i),
    .group_o     (grp)
  );

  word_assembler #(.NUM_BYTES(NUM_BYTES)) u_asm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .group_end_i  (group_end),
    .word_end_i   (word_end),
    .byte_idx_i   (byte_idx),
    .byte_i       (grp.data),
    .ctrl_bit_i   (grp.ctrl),
    .data_o       (data_o),
    .ctrl_o       (ctrl_o),
    .word_valid_o (word_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pad_err_o <= 1'b0;
    else if (group_end && grp.pad) pad_err_o <= 1'b1;
  end

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_err_o |=> pad_err_o);
  a_r6_valid_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(word_end));
  a_r5_update_only_on_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_o |-> ($stable(data_o) && $stable(ctrl_o)));
endmodule

// File: tb/serial_word_deser_tb.sv
module serial_word_deser_tb;
  localparam int DATA_W = 32;
  localparam int NB     = DATA_W / 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              serial_i = 1'b0;
  logic [DATA_W-1:0] data_o;
  logic [NB-1:0]     ctrl_o;
  logic              word_valid_o;
  logic              pad_err_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [DATA_W-1:0] prev_d = '0;
  logic [NB-1:0]     prev_c = '0;

  // {ctrl, data}
  localparam logic [35:0] VECS [0:7] = '{
    {4'h0, 32'h0000_0002},
    {4'hF, 32'hFFFF_FFFF},
    {4'h1, 32'h1234_5678},
    {4'h8, 32'h8000_0001},
    {4'hA, 32'hA5A5_5A5A},
    {4'h5, 32'h0F0F_F0F0},
    {4'h0, 32'h0000_0000},
    {4'h6, 32'hDEAD_BEEF}
  };

  always #10 clk_i = ~clk_i;

  serial_word_deser #(.DATA_W(DATA_W)) u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .serial_i     (serial_i),
    .data_o       (data_o),
    .ctrl_o       (ctrl_o),
    .word_valid_o (word_valid_o),
    .pad_err_o    (pad_err_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    serial_i = b;
    @(posedge clk_i);
    #1;
  endtask

  task automatic send_word(input logic [DATA_W-1:0] d, input logic [NB-1:0] c,
                           input logic [NB-1:0] pad);
    for (int k = 0; k < NB; k++) begin
      for (int i = 0; i < 10; i++) begin
        logic b;
        b = (i < 8) ? d[k*8+i] : (i == 8) ? c[k] : pad[k];
        drive_bit(b);
        if (k == 0 && i == 0) chk("R6 strobe drops", 64'(word_valid_o), 64'd0);
        if (k == NB/2 && i == 4) begin
          chk("R5 data held", 64'(data_o), 64'(prev_d));
          chk("R5 ctrl held", 64'(ctrl_o), 64'(prev_c));
        end
        if (k == NB-1 && i == 8) chk("R6 no early strobe", 64'(word_valid_o), 64'd0);
      end
    end
    chk("R6 strobe at word end", 64'(word_valid_o), 64'd1);
    chk("R1 R2 data", 64'(data_o), 64'(d));
    chk("R2 ctrl", 64'(ctrl_o), 64'(c));
    prev_d = d;
    prev_c = c;
  endtask

  task automatic report;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R8 reset state
    chk("R8 reset data", 64'(data_o), 64'd0);
    chk("R8 reset ctrl", 64'(ctrl_o), 64'd0);
    chk("R8 reset strobe", 64'(word_valid_o), 64'd0);
    chk("R8 reset err", 64'(pad_err_o), 64'd0);
    rst_ni = 1'b1;
    // R3 lead-in driven as 1, must be dropped
    drive_bit(1'b1);
    // R4 back-to-back words from the table
    for (int v = 0; v < 8; v++) begin
      send_word(VECS[v][31:0], VECS[v][35:32], '0);
    end
    chk("R7 no pad error", 64'(pad_err_o), 64'd0);
    // R7 pad set in byte 2 only: data unaffected, flag set
    send_word(32'hCAFE_0042, 4'h2, 4'b0100);
    chk("R7 pad err set", 64'(pad_err_o), 64'd1);
    send_word(32'h1357_9BDF, 4'h9, '0);
    chk("R7 pad err sticky", 64'(pad_err_o), 64'd1);
    // R8 reset mid-word
    for (int i = 0; i < 15; i++) drive_bit(1'b1);
    rst_ni = 1'b0;
    #2;
    chk("R8 async clear data", 64'(data_o), 64'd0);
    chk("R8 async clear ctrl", 64'(ctrl_o), 64'd0);
    chk("R8 async clear err", 64'(pad_err_o), 64'd0);
    @(posedge clk_i);
    #1;
    rst_ni = 1'b1;
    prev_d = '0;
    prev_c = '0;
    // R3 lead-in driven as 0 this time; R8 framing restarts
    drive_bit(1'b0);
    send_word(32'h8765_4321, 4'hC, '0);
    send_word(32'h0000_00FF, 4'h1, '0);
    chk("R9 ctrl width", 64'($bits(ctrl_o)), 64'(NB));
    report();
  end
endmodule